// File: doc/BRIEF.md
# Coprocessor Compare Flag Unit

This block compares two 64-bit coprocessor register values and hands the host core a 32-bit status word carrying four condition flags. One of four comparison modes is selected per request: 32-bit signed integer, 64-bit signed integer, IEEE single precision or IEEE double precision. Each operand register is viewed as an upper and a lower 32-bit half, and the mode decides which halves take part and in which word order.

A request is one cycle with `cmp_valid` high. The flags are computed combinationally from the operands, captured into a status register at that clock edge, and `cmp_done` is high for the following cycle. The status register keeps its value until the next request, so the host may read it late. For integers the flags follow a subtraction `a - b`. For floats the flags report less-than, equal and greater-than.

Top module: `copro_cmp_flags`

## Requirements
- R1: The status word has N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27 to 0 are always zero.
- R2: `cmp_mode` encoding: 0 is 32-bit integer, 1 is 64-bit integer, 2 is single precision, 3 is double precision. When `cmp_valid` is sampled high at an edge, `cmp_status` takes the result at that edge and `cmp_done` is high for exactly the next cycle. Otherwise `cmp_done` is low.
- R3: Synchronous active-low reset clears `cmp_status` and `cmp_done` to zero. With `cmp_valid` low, `cmp_status` keeps its value whatever the other inputs do.
- R4: The 32-bit integer mode uses only bits 31:0 of each operand. Bits 63:32 have no effect on the result.
- R5: For integer modes, with res = a - b at the operand width, Z is 1 exactly when a equals b, and N equals the top bit of res.
- R6: For integer modes, V is 1 when the signed difference a - b does not fit the operand width.
- R7: For integer modes, C = (a<0 AND b>=0) OR (a<0 AND res>=0) OR (b>=0 AND res>=0), with signs at the operand width. This equals unsigned a >= b.
- R8: The 64-bit integer mode reads the value with bits 31:0 of the register as its low word and bits 63:32 as its high word.
- R9: Single-precision mode reads each value from bits 63:32 of its register. Bits 31:0 have no effect.
- R10: Double-precision mode reads the value with register bits 31:0 as the high word (sign, exponent, top of the fraction) and register bits 63:32 as the low word.
- R11: For float modes, N = (a < b), Z = (a == b) and C = (a > b) under IEEE ordering, and V is 0. +0 and -0 compare equal. Infinities order beyond all finite values.
- R12: For float modes, if either operand is a NaN (exponent all ones, fraction non-zero), then N, Z, C and V are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_valid | input | 1 | Request strobe; operands and mode sampled at the edge |
| cmp_mode | input | 2 | Comparison mode (see R2) |
| cmp_op_a | input | 64 | First register operand |
| cmp_op_b | input | 64 | Second register operand |
| cmp_status | output | 32 | Registered status word (see R1) |
| cmp_done | output | 1 | One-cycle pulse when a new status is present |

## Verification
Each integer mode is swept over all ordered pairs of a set of corner values: zero, one, minus one, both extremes and ordinary values. This separates the overflow, borrow and sign cases, so a flag taken from the wrong bit or the wrong width shows up. In 32-bit mode the unused upper halves carry varying junk, so any leak of those bits into the result is caught. Both float modes are swept over pairs drawn from signed zeros, normals of both signs, infinities, a quiet NaN and, for double, the smallest denormal and the largest finite value. These pairs cover sign ordering, magnitude ordering that reverses for negative values, zero equality and the NaN blanking. The half order of double words is exercised by values whose two halves differ. Idle cycles with changed inputs show that the status holds and that done does not repeat.

// File: rtl/cmpf_pkg.sv
// Package: shared types and constants for the compare flag unit.
// Assumes a 32-bit status word with the four flags in its top nibble.
package cmpf_pkg;

    localparam int STATUS_W = 32;
    localparam int FLAG_N_POS = 31;
    localparam int FLAG_Z_POS = 30;
    localparam int FLAG_C_POS = 29;
    localparam int FLAG_V_POS = 28;

    typedef enum logic [1:0] {
        MODE_INT32 = 2'd0,
        MODE_INT64 = 2'd1,
        MODE_SGL   = 2'd2,
        MODE_DBL   = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Place the flags in the status word; all other bits are zero.
    function automatic logic [STATUS_W-1:0] pack_status(input flags_t f);
        logic [STATUS_W-1:0] s;
        s = '0;
        s[FLAG_N_POS] = f.n;
        s[FLAG_Z_POS] = f.z;
        s[FLAG_C_POS] = f.c;
        s[FLAG_V_POS] = f.v;
        return s;
    endfunction

endpackage

// File: rtl/cmpf_int_core.sv
// Module: cmpf_int_core
// Computes the integer subtraction flags for a - b at width W.
// Assumes two's-complement operands; purely combinational.
module cmpf_int_core
    import cmpf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output flags_t       flags
);

    logic [W-1:0] diff;
    logic         a_neg;
    logic         b_neg;
    logic         d_neg;

    // Difference and sign bits at the operand width.
    always_comb begin
        diff  = a - b;
        a_neg = a[W-1];
        b_neg = b[W-1];
        d_neg = diff[W-1];
    end

    // Flag equations: zero, sign, borrow-style carry and signed overflow.
    always_comb begin
        flags.z = (diff == '0);
        flags.n = d_neg;
        flags.c = (a_neg & ~b_neg) | (a_neg & ~d_neg) | (~b_neg & ~d_neg);
        flags.v = (a_neg ^ b_neg) & (d_neg ^ a_neg);
    end

endmodule

// File: rtl/cmpf_fp_core.sv
// Module: cmpf_fp_core
// Orders two IEEE binary floating-point values of a given format.
// Assumes sign-magnitude encoding; NaN yields all-zero flags,
// signed zeros compare equal, V is always zero.
module cmpf_fp_core
    import cmpf_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output flags_t               flags
);

    localparam int FW = EXP_W + MAN_W + 1;

    logic [FW-2:0] mag_a;
    logic [FW-2:0] mag_b;
    logic          sgn_a;
    logic          sgn_b;
    logic          nan_any;
    logic          zeros;
    logic          mag_lt;
    logic          lt;
    logic          eq;
    logic          gt;

    // Split fields and classify the operands.
    always_comb begin
        sgn_a   = a[FW-1];
        sgn_b   = b[FW-1];
        mag_a   = a[FW-2:0];
        mag_b   = b[FW-2:0];
        nan_any = ((&a[FW-2 -: EXP_W]) && (|a[MAN_W-1:0])) ||
                  ((&b[FW-2 -: EXP_W]) && (|b[MAN_W-1:0]));
        zeros   = (mag_a == '0) && (mag_b == '0);
        mag_lt  = mag_a < mag_b;
    end

    // Three-way ordering in sign-magnitude form.
    always_comb begin
        lt = 1'b0;
        eq = 1'b0;
        gt = 1'b0;
        if (nan_any) begin
            lt = 1'b0;
        end else if (zeros || (a == b)) begin
            eq = 1'b1;
        end else if (sgn_a != sgn_b) begin
            lt = sgn_a;
            gt = sgn_b;
        end else if (!sgn_a) begin
            lt = mag_lt;
            gt = ~mag_lt;
        end else begin
            lt = ~mag_lt;
            gt = mag_lt;
        end
    end

    // Map ordering onto the flag set.
    always_comb begin
        flags.n = lt;
        flags.z = eq;
        flags.c = gt;
        flags.v = 1'b0;
    end

endmodule

// File: rtl/cmpf_result_reg.sv
// Module: cmpf_result_reg
// Captures the status word on a request and raises done for one cycle.
// Assumes synchronous active-low reset; status holds between requests.
module cmpf_result_reg #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] q,
    output logic          done
);

    // Status register, loaded only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // Done pulse one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= load;
        end
    end

endmodule

// File: rtl/copro_cmp_flags.sv
// Module: copro_cmp_flags
// Compares two coprocessor register operands in one of four modes and
// returns a registered status word with N/Z/C/V plus a done pulse.
// Assumes REG_W = 64 split in two 32-bit halves; result in one cycle.
module copro_cmp_flags
    import cmpf_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_valid,
    input  logic [1:0]          cmp_mode,
    input  logic [REG_W-1:0]    cmp_op_a,
    input  logic [REG_W-1:0]    cmp_op_b,
    output logic [STATUS_W-1:0] cmp_status,
    output logic                cmp_done
);

    localparam int HALF_W = REG_W / 2;
    localparam int N_INT  = 2;
    localparam int N_FP   = 2;

    flags_t int_flags [N_INT];
    flags_t fp_flags  [N_FP];
    flags_t sel_flags;
    logic [STATUS_W-1:0] next_status;

    // Integer comparators: index 0 uses the low half, index 1 the full word.
    for (genvar gi = 0; gi < N_INT; gi++) begin : g_int
        localparam int IW = (gi == 0) ? HALF_W : REG_W;
        cmpf_int_core #(.W(IW)) u_int (
            .a     (cmp_op_a[IW-1:0]),
            .b     (cmp_op_b[IW-1:0]),
            .flags (int_flags[gi])
        );
    end

    // Float comparators: index 0 single from the upper half, index 1 double
    // with the lower half as most significant word.
    for (genvar gf = 0; gf < N_FP; gf++) begin : g_fp
        if (gf == 0) begin : g_sgl
            cmpf_fp_core #(.EXP_W(8), .MAN_W(23)) u_fp (
                .a     (cmp_op_a[REG_W-1:HALF_W]),
                .b     (cmp_op_b[REG_W-1:HALF_W]),
                .flags (fp_flags[gf])
            );
        end else begin : g_dbl
            cmpf_fp_core #(.EXP_W(11), .MAN_W(52)) u_fp (
                .a     ({cmp_op_a[HALF_W-1:0], cmp_op_a[REG_W-1:HALF_W]}),
                .b     ({cmp_op_b[HALF_W-1:0], cmp_op_b[REG_W-1:HALF_W]}),
                .flags (fp_flags[gf])
            );
        end
    end

    // Mode select of the flag set.
    always_comb begin
        unique case (cmp_mode_e'(cmp_mode))
            MODE_INT32: sel_flags = int_flags[0];
            MODE_INT64: sel_flags = int_flags[1];
            MODE_SGL:   sel_flags = fp_flags[0];
            default:    sel_flags = fp_flags[1];
        endcase
        next_status = pack_status(sel_flags);
    end

    cmpf_result_reg #(.SW(STATUS_W)) u_res (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cmp_valid),
        .d    (next_status),
        .q    (cmp_status),
        .done (cmp_done)
    );

endmodule

// File: rtl/cmpf_checker.sv
// Module: cmpf_checker
// Protocol and flag-consistency properties for copro_cmp_flags.
// Assumes it is bound to the top module and sees its ports only.
module cmpf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmp_valid,
    input logic [1:0]  cmp_mode,
    input logic [31:0] cmp_status,
    input logic        cmp_done
);

    // R1: low status bits are never set after a request.
    a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (cmp_status[27:0] == 28'd0));

    // R2: a request yields done in the next cycle.
    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> cmp_done);

    // R2: no request, no done.
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !cmp_done);

    // R3: status holds while idle.
    a_r3_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(cmp_status));

    // R5: an integer zero result is never negative.
    a_r5_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_mode[1]) |=> !(cmp_status[31] && cmp_status[30]));

    // R7: equal integers always report carry.
    a_r7_equal_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_mode[1]) |=> (!cmp_status[30] || cmp_status[29]));

    // R11: float outcomes are mutually exclusive and V stays clear.
    a_r11_fp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_mode[1]) |=> ($onehot0(cmp_status[31:29]) && !cmp_status[28]));

endmodule

bind copro_cmp_flags cmpf_checker u_cmpf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_mode  (cmp_mode),
    .cmp_status(cmp_status),
    .cmp_done  (cmp_done)
);

// File: tb/test_copro_cmp_flags.sv
module test_copro_cmp_flags;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_mode = 2'd0;
    logic [63:0] cmp_op_a = '0;
    logic [63:0] cmp_op_b = '0;
    logic [31:0] cmp_status;
    logic        cmp_done;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    copro_cmp_flags i_copro_cmp_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .cmp_mode  (cmp_mode),
        .cmp_op_a  (cmp_op_a),
        .cmp_op_b  (cmp_op_b),
        .cmp_status(cmp_status),
        .cmp_done  (cmp_done)
    );

    function automatic logic [31:0] mk(bit n, bit z, bit c, bit v);
        return {n, z, c, v, 28'd0};
    endfunction

    // Integer expectation from arithmetic: C as unsigned a >= b (R7),
    // V from the true signed difference (R6), Z/N (R5).
    function automatic logic [31:0] exp_int(logic [63:0] a, logic [63:0] b, bit wide);
        logic [64:0] d;
        logic [63:0] r;
        logic [31:0] r32;
        logic [32:0] d32;
        if (wide) begin
            r = a - b;
            d = {a[63], a} - {b[63], b};
            return mk(r[63], a == b, a >= b, d[64] ^ d[63]);
        end
        r32 = a[31:0] - b[31:0];
        d32 = {a[31], a[31:0]} - {b[31], b[31:0]};
        return mk(r32[31], a[31:0] == b[31:0], a[31:0] >= b[31:0], d32[32] ^ d32[31]);
    endfunction

    function automatic real sgl_to_real(logic [31:0] s);
        logic [63:0] d;
        if (s[30:23] == 8'd0)
            d = {s[31], 63'd0};
        else if (s[30:23] == 8'hFF)
            d = {s[31], 11'h7FF, s[22:0], 29'd0};
        else
            d = {s[31], {3'b000, s[30:23]} + 11'd896, s[22:0], 29'd0};
        return $bitstoreal(d);
    endfunction

    // Float expectation from real comparisons (R11, R12).
    function automatic logic [31:0] exp_real(real x, real y);
        return mk(x < y, x == y, x > y, 1'b0);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply one request, then check status and done one cycle later (R2).
    task automatic apply(logic [1:0] m, logic [63:0] a, logic [63:0] b,
                         logic [31:0] exp, string tag);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_mode  = m;
        cmp_op_a  = a;
        cmp_op_b  = b;
        @(negedge clk);
        cmp_valid = 1'b0;
        check({tag, " R2 done"}, {31'd0, cmp_done}, 32'd1);
        check(tag, cmp_status, exp);
    endtask

    logic [31:0] i32v [8];
    logic [63:0] i64v [8];
    logic [31:0] sglv [11];
    logic [63:0] dblv [11];

    initial begin
        i32v = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
                 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678};
        i64v = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
                 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0000,
                 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000};
        sglv = '{32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
                 32'h4000_0000, 32'h3F00_0000, 32'h7F80_0000, 32'hFF80_0000,
                 32'h7FC0_0000, 32'h3FC0_0000, 32'hC000_0000};
        dblv = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                 64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0001,
                 64'h3FE0_0000_0000_0000, 64'h7FF0_0000_0000_0000,
                 64'hFFF0_0000_0000_0000, 64'h7FF8_0000_0000_0000,
                 64'h0000_0000_0000_0001, 64'h7FEF_FFFF_FFFF_FFFF};

        // R3: reset state with a request pending on the inputs.
        cmp_valid = 1'b1;
        cmp_op_a  = 64'h5;
        repeat (3) @(negedge clk);
        check("R3 reset status", cmp_status, 32'd0);
        check("R3 reset done", {31'd0, cmp_done}, 32'd0);
        cmp_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R6 R7 R1: 32-bit integer sweep, upper halves carry junk.
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                apply(2'd0, {32'hA5C3_0F96 ^ 32'(i * 77), i32v[i]},
                            {32'h3C5A_9E71 ^ 32'(j * 131), i32v[j]},
                      exp_int({32'd0, i32v[i]}, {32'd0, i32v[j]}, 1'b0),
                      "R1 R4 R5 R6 R7 int32");
            end
        end

        // R8 R5 R6 R7: 64-bit integer sweep.
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                apply(2'd1, i64v[i], i64v[j], exp_int(i64v[i], i64v[j], 1'b1),
                      "R1 R8 R5 R6 R7 int64");
            end
        end

        // R9 R11 R12: single sweep, lower halves carry junk.
        for (int i = 0; i < 11; i++) begin
            for (int j = 0; j < 11; j++) begin
                apply(2'd2, {sglv[i], 32'h0F0F_1234 + 32'(i)},
                            {sglv[j], 32'hF0E1_D2C3 - 32'(j)},
                      exp_real(sgl_to_real(sglv[i]), sgl_to_real(sglv[j])),
                      "R1 R9 R11 R12 single");
            end
        end

        // R10 R11 R12: double sweep, high word placed in register bits 31:0.
        for (int i = 0; i < 11; i++) begin
            for (int j = 0; j < 11; j++) begin
                apply(2'd3, {dblv[i][31:0], dblv[i][63:32]},
                            {dblv[j][31:0], dblv[j][63:32]},
                      exp_real($bitstoreal(dblv[i]), $bitstoreal(dblv[j])),
                      "R1 R10 R11 R12 double");
            end
        end

        // R3 R2: idle cycles with changed inputs keep status, no done.
        apply(2'd0, 64'h0, 64'h1, mk(1'b1, 1'b0, 1'b0, 1'b0), "R5 int32 before idle");
        for (int k = 0; k < 4; k++) begin
            cmp_mode = 2'(k);
            cmp_op_a = 64'h1111_2222_3333_4444 * 64'(k + 1);
            cmp_op_b = ~cmp_op_a;
            @(negedge clk);
            check("R3 idle hold", cmp_status, mk(1'b1, 1'b0, 1'b0, 1'b0));
            check("R2 idle no done", {31'd0, cmp_done}, 32'd0);
        end

        // R3: reset mid-run clears the held status.
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 reset clears", cmp_status, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule